// File: doc/BRIEF.md
# Display Link Training Sequencer

This block brings up a multi-lane serial display link. When `start` is pulsed it first writes the link configuration to the sink. It then runs a clock-recovery phase with training pattern 1 and an equalization phase with training pattern 2. Finally it turns training off at both ends and pulses `done`. All sink accesses go through an auxiliary-channel engine. The block asks for each access with a request that it holds until the engine returns a one-cycle acknowledge. That acknowledge may carry an error flag and, for reads, the returned bytes. The block drives the source transmitter's pattern select and its lane-0 drive levels. Whenever the sink asks for different levels, the block takes the new per-lane training bytes from an external adjust-computation unit. That unit is fed from the latched status bytes.

The controller is a single enumerated state machine. Its states are:
- `S_IDLE`: waits for `start`.
- `S_CFG`: writes the configuration.
- `S_DRIVE`: latches the source pattern and drive levels.
- `S_PATW`: writes the sink's pattern code.
- `S_SETW`: writes the four per-lane training bytes.
- `S_STATR`: reads the six status bytes.
- `S_EVAL`: judges the status.
- `S_OFF`: clears the pattern at both ends.
- `S_FIN`: the `done` cycle.

Transitions:
- `S_IDLE`→`S_CFG` on `start`.
- `S_CFG`→`S_DRIVE`, `S_PATW`→`S_SETW` and `S_SETW`→`S_STATR` on a clean acknowledge.
- `S_STATR`→`S_EVAL` on a clean acknowledge.
- Any access state goes to `S_OFF` on an errored acknowledge.
- `S_EVAL`→`S_DRIVE` to iterate, or when clock recovery is left for equalization.
- `S_EVAL`→`S_OFF` when equalization succeeds or is exhausted.
- `S_OFF`→`S_FIN` on acknowledge.
- `S_FIN`→`S_IDLE`.

Clock recovery is always followed by equalization, even when it gives up. `cr_ok` records whether it succeeded.

Top module: `link_train_seq`

## Requirements
- R1: After reset `busy`, `done`, `aux_req`, `cr_ok`, `eq_ok`, `train_fail` and `pat_sel` are all zero, and no request is issued while `busy` is low.
- R2: On `start` the first request is a 9-byte write to address 0x100. Byte 0 is `rate_code`. Byte 1 is `lane_cnt`, with bit 7 set only when `sink_rev` is 0x11 or higher. The other bytes are zero.
- R3: Each training iteration runs four steps in this order:
  - It sets `pat_sel` (1 = pattern 1, 2 = pattern 2) and takes `drv_swing`/`drv_pre` from bits [1:0]/[4:3] of lane 0's training byte.
  - It writes that pattern code as one byte to 0x102.
  - It writes the four training bytes (lane n in data byte n) to 0x103.
  - It reads 6 status bytes from 0x202.
  
  All training bytes are zero at the first iteration.
- R4: Clock recovery succeeds when bit 0 of every active lane's status nibble is set. Lane n's nibble sits in status byte n/2 at bit 4·(n mod 2). Lanes n ≥ `lane_cnt` are ignored. On success `cr_ok` is set.
- R5: Clock recovery is abandoned, without setting `cr_ok`, when every active lane's current training byte has bit 2 (max swing reached) set. Equalization still follows.
- R6: Clock recovery is abandoned after the fifth attempt at an unchanged lane-0 swing. The count restarts at one whenever the swing changes. Equalization still follows.
- R7: Equalization succeeds only when status byte 2 bit 0 (interlane align) is set and every active lane's nibble has bits 0, 1 and 2 all set. On success `eq_ok` is set.
- R8: After 5 failed equalization iterations `train_fail` is set and `eq_ok` stays clear.
- R9: Training ends by forcing `pat_sel` to 0 and writing byte 0x00 to 0x102. `done` then pulses for exactly one cycle with `busy` low.
- R10: An acknowledge with `aux_err` set stops the sequence: no further training request is made, `train_fail` is set and the end step of R9 follows.
- R11: After a failed evaluation that continues the same phase, the next iteration writes the training bytes sampled from `adj_set` and drives its lane-0 levels.
- R12: A request holds `aux_req`, its address and its data stable until `aux_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a training run (sampled in idle) |
| lane_cnt | input | 3 | Active lane count (1, 2 or 4) |
| rate_code | input | 8 | Link rate code for configuration byte 0 |
| sink_rev | input | 8 | Sink capability revision |
| adj_set | input | 32 | New per-lane training bytes from the adjust unit |
| aux_req | output | 1 | Auxiliary request valid |
| aux_wr | output | 1 | 1 = write, 0 = read |
| aux_addr | output | 16 | Sink address |
| aux_len | output | 4 | Byte count |
| aux_wdata | output | 72 | Write bytes, byte k at bits [8k+7:8k] |
| aux_ack | input | 1 | One-cycle completion |
| aux_err | input | 1 | Completion carries an error |
| aux_rdata | input | 48 | Read bytes, byte k at bits [8k+7:8k] |
| link_status | output | 48 | Last status bytes read, for the adjust unit |
| pat_sel | output | 2 | Source pattern: 0 off, 1 pattern 1, 2 pattern 2 |
| drv_swing | output | 2 | Source voltage swing level |
| drv_pre | output | 2 | Source pre-emphasis level |
| busy | output | 1 | Sequence running |
| done | output | 1 | One-cycle end pulse |
| cr_ok | output | 1 | Clock recovery succeeded |
| eq_ok | output | 1 | Equalization succeeded |
| train_fail | output | 1 | Equalization exhausted or auxiliary error |

## Verification
The bench builds the block with its default limits of five same-swing attempts and five equalization iterations. With these values both abort windows are short enough to run to completion: a stuck swing gives exactly five clock-recovery reads, and a swing change stretches that to six. Four lanes by default let the bench mask off lanes one to three through `lane_cnt` and show that their status and max-swing bits are ignored. The bench also adds acknowledge latency so that requests must be held across several cycles.

// File: rtl/lt_pkg.sv
package lt_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CFG,
        S_DRIVE,
        S_PATW,
        S_SETW,
        S_STATR,
        S_EVAL,
        S_OFF,
        S_FIN
    } lt_state_e;

    localparam logic [15:0] CFG_ADDR  = 16'h0100;
    localparam logic [15:0] PAT_ADDR  = 16'h0102;
    localparam logic [15:0] SET_ADDR  = 16'h0103;
    localparam logic [15:0] STAT_ADDR = 16'h0202;

    localparam logic [7:0] ENH_REV   = 8'h11;
    localparam logic [7:0] ENH_BIT   = 8'h80;

endpackage

// File: rtl/lt_status_eval.sv
module lt_status_eval #(
    parameter int LANES      = 4,
    parameter int STAT_BYTES = 6,
    localparam int SET_W     = LANES * 8,
    localparam int STAT_W    = STAT_BYTES * 8,
    localparam int ALIGN_IDX = ((LANES + 1) / 2) * 8
) (
    input  logic [STAT_W-1:0] stat,
    input  logic [SET_W-1:0]  tset,
    input  logic [2:0]        lane_cnt,
    output logic              cr_all,
    output logic              eq_all,
    output logic              max_all
);
    logic [LANES-1:0] cr_l, eq_l, mx_l;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int NIB = (i / 2) * 8 + (i % 2) * 4;
        logic       act;
        logic [3:0] nib;
        assign act     = (32'(i) < 32'(lane_cnt));
        assign nib     = stat[NIB +: 4];
        assign cr_l[i] = !act || nib[0];
        assign eq_l[i] = !act || (&nib[2:0]);
        assign mx_l[i] = !act || tset[i*8 + 2];
    end

    assign cr_all  = &cr_l;
    assign eq_all  = (&eq_l) && stat[ALIGN_IDX];
    assign max_all = &mx_l;

endmodule

// File: rtl/lt_aux_fmt.sv
module lt_aux_fmt
    import lt_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int CFG_BYTES  = 9,
    parameter int STAT_BYTES = 6,
    localparam int SET_W     = LANES * 8,
    localparam int DW        = CFG_BYTES * 8,
    localparam int LEN_W     = $clog2(CFG_BYTES + 1)
) (
    input  lt_state_e        state,
    input  logic             phase_eq,
    input  logic [7:0]       rate_code,
    input  logic [2:0]       lane_cnt,
    input  logic [7:0]       sink_rev,
    input  logic [SET_W-1:0] tset,
    output logic             req,
    output logic             wr,
    output logic [15:0]      addr,
    output logic [LEN_W-1:0] len,
    output logic [DW-1:0]    wdata
);
    always_comb begin
        req   = 1'b0;
        wr    = 1'b0;
        addr  = '0;
        len   = '0;
        wdata = '0;
        unique case (state)
            S_CFG: begin
                req          = 1'b1;
                wr           = 1'b1;
                addr         = CFG_ADDR;
                len          = LEN_W'(CFG_BYTES);
                wdata[7:0]   = rate_code;
                wdata[15:8]  = 8'(lane_cnt) | ((sink_rev >= ENH_REV) ? ENH_BIT : 8'h00);
            end
            S_PATW: begin
                req        = 1'b1;
                wr         = 1'b1;
                addr       = PAT_ADDR;
                len        = LEN_W'(1);
                wdata[7:0] = phase_eq ? 8'h02 : 8'h01;
            end
            S_SETW: begin
                req               = 1'b1;
                wr                = 1'b1;
                addr              = SET_ADDR;
                len               = LEN_W'(LANES);
                wdata[SET_W-1:0]  = tset;
            end
            S_STATR: begin
                req  = 1'b1;
                addr = STAT_ADDR;
                len  = LEN_W'(STAT_BYTES);
            end
            S_OFF: begin
                req  = 1'b1;
                wr   = 1'b1;
                addr = PAT_ADDR;
                len  = LEN_W'(1);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/link_train_seq.sv
module link_train_seq
    import lt_pkg::*;
#(
    parameter int LANES         = 4,
    parameter int CFG_BYTES     = 9,
    parameter int STAT_BYTES    = 6,
    parameter int CR_SAME_LIMIT = 5,
    parameter int EQ_MAX_ITER   = 5,
    localparam int SET_W        = LANES * 8,
    localparam int DW           = CFG_BYTES * 8,
    localparam int STAT_W       = STAT_BYTES * 8,
    localparam int LEN_W        = $clog2(CFG_BYTES + 1),
    localparam int CNT_W        = $clog2(CR_SAME_LIMIT + 1),
    localparam int IT_W         = $clog2(EQ_MAX_ITER + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        lane_cnt,
    input  logic [7:0]        rate_code,
    input  logic [7:0]        sink_rev,
    input  logic [SET_W-1:0]  adj_set,
    output logic              aux_req,
    output logic              aux_wr,
    output logic [15:0]       aux_addr,
    output logic [LEN_W-1:0]  aux_len,
    output logic [DW-1:0]     aux_wdata,
    input  logic              aux_ack,
    input  logic              aux_err,
    input  logic [STAT_W-1:0] aux_rdata,
    output logic [STAT_W-1:0] link_status,
    output logic [1:0]        pat_sel,
    output logic [1:0]        drv_swing,
    output logic [1:0]        drv_pre,
    output logic              busy,
    output logic              done,
    output logic              cr_ok,
    output logic              eq_ok,
    output logic              train_fail
);
    lt_state_e         state, nxt;
    logic              phase_eq;
    logic [SET_W-1:0]  tset_q;
    logic [STAT_W-1:0] stat_q;
    logic [CNT_W-1:0]  same_cnt_q, same_n;
    logic [1:0]        last_sw_q;
    logic [IT_W-1:0]   eq_iter_q;
    logic              cr_all, eq_all, max_all;
    logic              cr_exit, eq_last;

    lt_status_eval #(.LANES(LANES), .STAT_BYTES(STAT_BYTES)) u_eval (
        .stat    (stat_q),
        .tset    (tset_q),
        .lane_cnt(lane_cnt),
        .cr_all  (cr_all),
        .eq_all  (eq_all),
        .max_all (max_all)
    );

    lt_aux_fmt #(.LANES(LANES), .CFG_BYTES(CFG_BYTES), .STAT_BYTES(STAT_BYTES)) u_fmt (
        .state    (state),
        .phase_eq (phase_eq),
        .rate_code(rate_code),
        .lane_cnt (lane_cnt),
        .sink_rev (sink_rev),
        .tset     (tset_q),
        .req      (aux_req),
        .wr       (aux_wr),
        .addr     (aux_addr),
        .len      (aux_len),
        .wdata    (aux_wdata)
    );

    // Same-swing attempt count including the attempt just judged
    assign same_n  = (tset_q[1:0] == last_sw_q) ? same_cnt_q + CNT_W'(1) : CNT_W'(1);
    assign cr_exit = cr_all || max_all || (same_n == CNT_W'(CR_SAME_LIMIT));
    assign eq_last = (eq_iter_q == IT_W'(EQ_MAX_ITER - 1));

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (start) nxt = S_CFG;
            S_CFG:   if (aux_ack) nxt = aux_err ? S_OFF : S_DRIVE;
            S_DRIVE: nxt = S_PATW;
            S_PATW:  if (aux_ack) nxt = aux_err ? S_OFF : S_SETW;
            S_SETW:  if (aux_ack) nxt = aux_err ? S_OFF : S_STATR;
            S_STATR: if (aux_ack) nxt = aux_err ? S_OFF : S_EVAL;
            S_EVAL:  nxt = (phase_eq && (eq_all || eq_last)) ? S_OFF : S_DRIVE;
            S_OFF:   if (aux_ack) nxt = S_FIN;
            S_FIN:   nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_eq   <= 1'b0;
            tset_q     <= '0;
            stat_q     <= '0;
            same_cnt_q <= '0;
            last_sw_q  <= '0;
            eq_iter_q  <= '0;
            pat_sel    <= '0;
            drv_swing  <= '0;
            drv_pre    <= '0;
            cr_ok      <= 1'b0;
            eq_ok      <= 1'b0;
            train_fail <= 1'b0;
        end else begin
            if (state == S_IDLE && start) begin
                phase_eq   <= 1'b0;
                tset_q     <= '0;
                same_cnt_q <= '0;
                last_sw_q  <= '0;
                eq_iter_q  <= '0;
                cr_ok      <= 1'b0;
                eq_ok      <= 1'b0;
                train_fail <= 1'b0;
            end
            if (state == S_DRIVE) begin
                pat_sel   <= phase_eq ? 2'd2 : 2'd1;
                drv_swing <= tset_q[1:0];
                drv_pre   <= tset_q[4:3];
            end
            if (aux_req && aux_ack && aux_err) train_fail <= 1'b1;
            if (state == S_STATR && aux_ack && !aux_err) stat_q <= aux_rdata;
            if (state == S_EVAL) begin
                if (!phase_eq) begin
                    if (cr_exit) begin
                        phase_eq <= 1'b1;
                        cr_ok    <= cr_all;
                    end else begin
                        same_cnt_q <= same_n;
                        last_sw_q  <= tset_q[1:0];
                        tset_q     <= adj_set;
                    end
                end else if (eq_all) begin
                    eq_ok <= 1'b1;
                end else if (eq_last) begin
                    train_fail <= 1'b1;
                end else begin
                    eq_iter_q <= eq_iter_q + IT_W'(1);
                    tset_q    <= adj_set;
                end
            end
            if (nxt == S_OFF && state != S_OFF) pat_sel <= 2'd0;
        end
    end

    assign busy        = (state != S_IDLE) && (state != S_FIN);
    assign done        = (state == S_FIN);
    assign link_status = stat_q;

endmodule

// File: rtl/lt_checker.sv
module lt_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        aux_req,
    input logic        aux_wr,
    input logic [15:0] aux_addr,
    input logic [3:0]  aux_len,
    input logic [71:0] aux_wdata,
    input logic        aux_ack,
    input logic [1:0]  pat_sel,
    input logic        busy,
    input logic        done,
    input logic        eq_ok,
    input logic        train_fail
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !aux_req);  // R1
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done) |=> busy);  // R2
    AST_SET_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_req && aux_wr && aux_len == 4'd4) |-> aux_addr == 16'h0103);  // R3
    AST_FAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(train_fail && eq_ok));  // R8
    AST_DONE_PAT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> pat_sel == 2'd0);  // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R9
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_req && !aux_ack) |=> aux_req);  // R12
    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_req && !aux_ack) |=> ($stable(aux_addr) && $stable(aux_wdata)));  // R12
endmodule

bind link_train_seq lt_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .aux_req   (aux_req),
    .aux_wr    (aux_wr),
    .aux_addr  (aux_addr),
    .aux_len   (aux_len),
    .aux_wdata (aux_wdata),
    .aux_ack   (aux_ack),
    .pat_sel   (pat_sel),
    .busy      (busy),
    .done      (done),
    .eq_ok     (eq_ok),
    .train_fail(train_fail)
);

// File: tb/sim_link_train_seq.sv
`timescale 1ns/1ps
module sim_link_train_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  lane_cnt = 3'd4;
    logic [7:0]  rate_code = 8'h0a;
    logic [7:0]  sink_rev = 8'h11;
    logic [31:0] adj_set = '0;
    logic        aux_req, aux_wr;
    logic [15:0] aux_addr;
    logic [3:0]  aux_len;
    logic [71:0] aux_wdata;
    logic        aux_ack = 1'b0;
    logic        aux_err = 1'b0;
    logic [47:0] aux_rdata = '0;
    logic [47:0] link_status;
    logic [1:0]  pat_sel, drv_swing, drv_pre;
    logic        busy, done, cr_ok, eq_ok, train_fail;

    always #2.5 clk = ~clk;

    link_train_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .lane_cnt(lane_cnt),
        .rate_code(rate_code), .sink_rev(sink_rev), .adj_set(adj_set),
        .aux_req(aux_req), .aux_wr(aux_wr), .aux_addr(aux_addr),
        .aux_len(aux_len), .aux_wdata(aux_wdata), .aux_ack(aux_ack),
        .aux_err(aux_err), .aux_rdata(aux_rdata), .link_status(link_status),
        .pat_sel(pat_sel), .drv_swing(drv_swing), .drv_pre(drv_pre),
        .busy(busy), .done(done), .cr_ok(cr_ok), .eq_ok(eq_ok),
        .train_fail(train_fail)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // Responder configuration and log
    int          lat = 0;
    int          err_at = 0;
    logic [47:0] stat_val = '0;
    int          wcnt = 0;
    int          tx_n, rd_n, p0, p1, p2;
    int          order_bad, drv_bad, pat_bad, cfg_len;
    logic [7:0]  cfg_b0, cfg_b1, last_code;
    logic [31:0] last_set;
    logic [15:0] prev_addr;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (aux_ack) begin
                aux_ack = 1'b0;
                aux_err = 1'b0;
            end else if (aux_req) begin
                if (wcnt < lat) wcnt++;
                else begin
                    wcnt = 0;
                    tx_n++;
                    aux_err   = (tx_n == err_at);
                    aux_rdata = stat_val;
                    if (aux_wr && aux_addr == 16'h0100) begin
                        cfg_b0 = aux_wdata[7:0];
                        cfg_b1 = aux_wdata[15:8];
                        cfg_len = int'(aux_len);
                        if (aux_wdata[71:16] != '0) order_bad++;
                    end
                    if (aux_wr && aux_addr == 16'h0102) begin
                        last_code = aux_wdata[7:0];
                        if (last_code == 8'd0) p0++;
                        else if (last_code == 8'd1) p1++;
                        else if (last_code == 8'd2) p2++;
                        if (pat_sel != last_code[1:0]) pat_bad++;
                    end
                    if (aux_wr && aux_addr == 16'h0103) begin
                        last_set = aux_wdata[31:0];
                        if (prev_addr != 16'h0102 || aux_len != 4'd4) order_bad++;
                        if (drv_swing != aux_wdata[1:0] || drv_pre != aux_wdata[4:3]) drv_bad++;
                    end
                    if (!aux_wr && aux_addr == 16'h0202) begin
                        rd_n++;
                        if (prev_addr != 16'h0103 || aux_len != 4'd6) order_bad++;
                    end
                    prev_addr = aux_addr;
                    aux_ack = 1'b1;
                end
            end
        end
    end

    task automatic run_train(input logic [2:0] lanes, input logic [7:0] rev,
                             input logic [31:0] adj, input logic [47:0] st,
                             input int latency, input int errix, output bit ok);
        tx_n = 0; rd_n = 0; p0 = 0; p1 = 0; p2 = 0;
        order_bad = 0; drv_bad = 0; pat_bad = 0; cfg_len = 0;
        cfg_b0 = 0; cfg_b1 = 0; last_code = 8'hff; last_set = 32'hdeadbeef;
        prev_addr = 16'h0;
        lane_cnt = lanes; sink_rev = rev; adj_set = adj; stat_val = st;
        lat = latency; err_at = errix;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ok = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (done) begin ok = 1; break; end
        end
        chk(ok, "R9 done reached", longint'(ok), 1);
    endtask

    task automatic end_checks(input string tag);
        chk(pat_sel == 2'd0 && p0 == 1 && last_code == 8'd0, {tag, " R9 off step"}, longint'(pat_sel), 0);
        chk(!busy, {tag, " R9 busy low at done"}, longint'(busy), 0);
        @(negedge clk);
        chk(!done, {tag, " R9 done one cycle"}, longint'(done), 0);
        chk(order_bad == 0 && drv_bad == 0 && pat_bad == 0, {tag, " R3 order/levels"},
            longint'(order_bad + drv_bad + pat_bad), 0);
    endtask

    task automatic t_reset();
        chk(!busy && !done && !aux_req && pat_sel == 2'd0, "R1 idle outputs", longint'({busy, done, aux_req, pat_sel}), 0);
        chk(!cr_ok && !eq_ok && !train_fail, "R1 flags clear", longint'({cr_ok, eq_ok, train_fail}), 0);
    endtask

    task automatic t_happy();
        bit ok;
        rate_code = 8'h14;
        run_train(3'd4, 8'h12, 32'h0, 48'h0000_0001_7777, 3, 0, ok);
        chk(cfg_len == 9 && cfg_b0 == 8'h14, "R2 cfg length/rate", longint'(cfg_b0), 8'h14);
        chk(cfg_b1 == 8'h84, "R2 lane byte with enhanced bit", longint'(cfg_b1), 8'h84);
        chk(rd_n == 2 && p1 == 1 && p2 == 1, "R3 one iteration per phase", longint'(rd_n), 2);
        chk(last_set == 32'h0, "R3 training bytes start at zero", longint'(last_set), 0);
        chk(cr_ok && eq_ok && !train_fail, "R4 R7 success flags", longint'({cr_ok, eq_ok, train_fail}), 3'b110);
        end_checks("happy");
    endtask

    task automatic t_masked();
        bit ok;
        // 2 lanes; lanes 2,3 status all zero; old revision
        run_train(3'd2, 8'h10, 32'h0, 48'h0000_0001_0077, 0, 0, ok);
        chk(cfg_b1 == 8'h02, "R2 no enhanced bit below 0x11", longint'(cfg_b1), 8'h02);
        chk(rd_n == 2 && cr_ok && eq_ok, "R4 R7 inactive lanes ignored", longint'(rd_n), 2);
        end_checks("masked");
    endtask

    task automatic t_align();
        bit ok;
        run_train(3'd4, 8'h11, 32'h0, 48'h0000_0000_7777, 0, 0, ok);
        chk(cr_ok && !eq_ok, "R7 align bit required", longint'({cr_ok, eq_ok}), 2'b10);
        chk(rd_n == 6 && p2 == 5, "R8 five equalization iterations", longint'(rd_n), 6);
        chk(train_fail, "R8 fail flag", longint'(train_fail), 1);
        end_checks("align");
    endtask

    task automatic t_stuck();
        bit ok;
        run_train(3'd4, 8'h11, 32'h0, 48'h0, 1, 0, ok);
        chk(p1 == 5, "R6 abort after fifth same-swing attempt", longint'(p1), 5);
        chk(!cr_ok && p2 == 5 && rd_n == 10, "R6 equalization still follows", longint'(p2), 5);
        chk(train_fail && !eq_ok, "R8 exhausted", longint'({train_fail, eq_ok}), 2'b10);
        end_checks("stuck");
    endtask

    task automatic t_maxswing();
        bit ok;
        // lane 0 requests swing 2 with max flag; lanes 1-3 inactive
        run_train(3'd1, 8'h11, 32'h0000_0006, 48'h0, 0, 0, ok);
        chk(p1 == 2 && !cr_ok, "R5 abort on max swing", longint'(p1), 2);
        chk(p2 == 5, "R5 equalization follows abort", longint'(p2), 5);
        chk(last_set == 32'h0000_0006, "R11 adjusted bytes written", longint'(last_set), 6);
        chk(drv_swing == 2'd2 && drv_pre == 2'd0, "R11 lane0 drive levels", longint'(drv_swing), 2);
        end_checks("maxswing");
    endtask

    task automatic t_swing_change();
        bit ok;
        // swing 1 pre-emphasis 1 requested, no max flags
        run_train(3'd4, 8'h11, 32'h0909_0909, 48'h0, 0, 0, ok);
        chk(p1 == 6, "R6 count restarts on swing change", longint'(p1), 6);
        chk(drv_swing == 2'd1 && drv_pre == 2'd1, "R11 drive from adjusted lane0", longint'({drv_swing, drv_pre}), 4'b0101);
        end_checks("swchg");
    endtask

    task automatic t_aux_err();
        bit ok;
        // third transaction (training-byte write) errors
        run_train(3'd4, 8'h11, 32'h0, 48'h0000_0001_7777, 2, 3, ok);
        chk(tx_n == 4 && rd_n == 0, "R10 sequence stops after error", longint'(tx_n), 4);
        chk(p1 == 1 && p2 == 0, "R10 no further training request", longint'(p2), 0);
        chk(train_fail && !cr_ok && !eq_ok, "R10 failure reported", longint'({train_fail, cr_ok, eq_ok}), 3'b100);
        end_checks("auxerr");
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R9 actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_happy();
        t_masked();
        t_align();
        t_stuck();
        t_maxswing();
        t_swing_change();
        t_aux_err();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule